// File: doc/BRIEF.md
# I2C target with read-request clock stretching

This block is the bus-facing half of an I2C target (slave). Software programs the address it answers to, picks 7-bit or 10-bit matching, and then switches it on. Once enabled, the block watches the bus for START and STOP, shifts in the address byte or bytes, and compares them with the programmed address. On a match it drives ACK and takes the direction bit. A write hands each received byte to the host logic as a one-cycle pulse on a byte port, and every data byte is acknowledged.

A read raises a read-request flag and holds SCL low until software writes the byte to send. The byte then goes out MSB first. The master's acknowledge decides what comes next: ACK opens another read request, and NACK sends the block back to idle. SDA and SCL are open-drain. Each has a sampled input and an output-enable, and an asserted enable pulls the line low.

Top module: `i2c_tgt`

## Requirements
- R1: After reset the control register reads 0x0000, the address register reads 0x055, the enable register reads 0, the raw status reads 0, `irq` is 0, and both `sda_oe` and `scl_oe` are 0.
- R2: While the enable bit (offset 2, bit 0) is 0, the block never drives SDA or SCL. A matching address is not acknowledged.
- R3: Writes to the control register (offset 0) and the address register (offset 1, bits 9:0) are ignored while the enable bit is 1.
- R4: A control write with bit 0 (master request) set to 1 and bit 6 (target disable) set to 0 is ignored. The control fields are bit 0, bit 3 (1 selects 10-bit matching) and bit 6.
- R5: In 7-bit mode a first byte whose upper seven bits equal address bits 6:0 is acknowledged. Any other byte is not, and the block then ignores the bus until the next START or STOP.
- R6: After a matching write address, each received byte is acknowledged and appears on `rx_data` with a one-cycle `rx_valid` pulse. The last byte also reads back at offset 3.
- R7: After a matching read address, the block holds SCL low and sets raw status bit 5 (offset 4). SCL is released in the cycle after software writes the transmit byte to offset 3.
- R8: The transmit byte is sent MSB first. A master ACK starts another read request with SCL held. A master NACK releases both lines and sends the block to idle.
- R9: In 10-bit mode the first byte must be 11110, then address bits 9:8, then write (0), and the second byte must equal bits 7:0. A repeated START followed by 11110, bits 9:8 and read (1) is acknowledged only if both earlier phases matched. A STOP or a failed phase forgets the match.
- R10: `irq` is raw bit 5 gated by mask bit 5 (offset 5). Writing 1 to raw bit 5 clears it.
- R11: With control bit 6 set to 1, the block does not respond even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is new |
| irq | output | 1 | Masked read-request interrupt |

## Verification
The bench builds the block with the default reset address of 0x055 and a bus half-period of six clocks. That short bus period makes a full sweep of all 128 7-bit address bytes affordable, along with a check that the bus is ignored after each miss. It also covers all four upper-bit patterns of the 10-bit header. Reprogramming the address to 0x2A5 brings the 10-bit write phases, the repeated-START read, and the forgetting of a match after STOP or a failed phase within reach. The stretch release is checked at its exact cycle.

// File: rtl/i2c_tgt.sv
module i2c_tgt #(
  parameter logic [9:0] ADDR_RST = 10'h055
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        scl_i,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_SAR = 3'd1, A_EN = 3'd2,
                         A_DATA = 3'd3, A_RAW = 3'd4, A_MASK = 3'd5;

  typedef enum logic [3:0] {S_IDLE, S_ADDR, S_ADDR2, S_ACK, S_RX,
                            S_TXW, S_TX, S_TXACK, S_SKIP} st_t;

  logic       ten, sdis, mst, en, rd_req, mask, hi_ok, nack;
  logic [9:0] sar;
  logic [7:0] sh, rxbuf;
  logic [3:0] cnt;
  logic [2:0] scl_q, sda_q;
  st_t        st, nxt;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, reg_wdata[15:10]};

  wire scl_s = scl_q[1], scl_p = scl_q[2];
  wire sda_s = sda_q[1], sda_p = sda_q[2];
  wire rise  = scl_s & ~scl_p;
  wire fall  = ~scl_s & scl_p;
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;
  wire active = en & ~sdis;
  wire busy_ok = active & ~start & ~stop;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_sar  = reg_we && reg_addr == A_SAR;
  wire wr_en   = reg_we && reg_addr == A_EN;
  wire wr_data = reg_we && reg_addr == A_DATA;
  wire wr_raw  = reg_we && reg_addr == A_RAW;
  wire wr_mask = reg_we && reg_addr == A_MASK;

  wire hdr10 = sh[7:3] == 5'b11110 && sh[2:1] == sar[9:8];
  wire m7    = sh[7:1] == sar[6:0];
  wire last_bit = fall && cnt == 4'd8;

  wire req_set = busy_ok && fall &&
                 ((st == S_ACK && nxt == S_TXW) || (st == S_TXACK && !nack));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ten <= 1'b0; sdis <= 1'b0; mst <= 1'b0;
      sar <= ADDR_RST; en <= 1'b0; mask <= 1'b0; rd_req <= 1'b0;
    end else begin
      if (wr_ctrl && !en && !(reg_wdata[0] && !reg_wdata[6])) begin
        mst  <= reg_wdata[0];
        ten  <= reg_wdata[3];
        sdis <= reg_wdata[6];
      end
      if (wr_sar && !en) sar <= reg_wdata[9:0];
      if (wr_en)   en   <= reg_wdata[0];
      if (wr_mask) mask <= reg_wdata[5];
      if (req_set) rd_req <= 1'b1;
      else if (wr_raw && reg_wdata[5]) rd_req <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; sh <= '0; cnt <= '0;
      hi_ok <= 1'b0; nack <= 1'b0; rxbuf <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        st <= S_IDLE; hi_ok <= 1'b0;
      end else if (start) begin
        st <= S_ADDR; cnt <= '0;
      end else if (stop) begin
        st <= S_IDLE; hi_ok <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_ADDR2, S_RX:
            if (rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (last_bit) begin
              cnt <= '0;
              st  <= S_ACK;
              if (st == S_RX) begin
                rx_valid <= 1'b1; rxbuf <= sh; nxt <= S_RX;
              end else if (st == S_ADDR2) begin
                if (sh == sar[7:0]) begin nxt <= S_RX; hi_ok <= 1'b1; end
                else begin st <= S_SKIP; hi_ok <= 1'b0; end
              end else if (!ten) begin
                if (m7) nxt <= sh[0] ? S_TXW : S_RX;
                else st <= S_SKIP;
              end else if (hdr10 && !sh[0]) begin
                nxt <= S_ADDR2; hi_ok <= 1'b0;
              end else if (hdr10 && hi_ok) begin
                nxt <= S_TXW;
              end else begin
                st <= S_SKIP; hi_ok <= 1'b0;
              end
            end
          S_ACK:
            if (fall) begin st <= nxt; cnt <= '0; end
          S_TXW:
            if (wr_data) begin st <= S_TX; sh <= reg_wdata[7:0]; cnt <= '0; end
          S_TX:
            if (fall) begin
              sh  <= {sh[6:0], 1'b1};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) st <= S_TXACK;
            end
          S_TXACK:
            if (rise) nack <= sda_s;
            else if (fall) st <= nack ? S_SKIP : S_TXW;
          default: ;
        endcase
      end
    end

  assign sda_oe  = (st == S_ACK) | (st == S_TX & ~sh[7]);
  assign scl_oe  = st == S_TXW;
  assign rx_data = rxbuf;
  assign irq     = rd_req & mask;

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = {9'b0, sdis, 2'b0, ten, 2'b0, mst};
      A_SAR:   reg_rdata = {6'b0, sar};
      A_EN:    reg_rdata = {15'b0, en};
      A_DATA:  reg_rdata = {8'b0, rxbuf};
      A_RAW:   reg_rdata = {10'b0, rd_req, 5'b0};
      A_MASK:  reg_rdata = {10'b0, mask, 5'b0};
      default: reg_rdata = '0;
    endcase
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [9:0] sar,
  input logic       sdis,
  input logic       mst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       rx_valid
);
  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!sda_oe && !scl_oe));

  p_addr_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(sar));

  p_legal_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mst |-> sdis);

  p_rx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_release_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> ($past(reg_we) && ($past(reg_addr) == 3'd3 || $past(reg_addr) == 3'd2)));

  p_sda_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sar(sar), .sdis(sdis), .mst(mst),
  .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe), .reg_we(reg_we),
  .reg_addr(reg_addr), .rx_valid(rx_valid)
);

// File: tb/i2c_tgt_tb_top.sv
module i2c_tgt_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        scl_oe, sda_oe, rx_valid, irq;
  logic [7:0]  rx_data;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  wire         scl_l = scl_m & ~scl_oe;
  wire         sda_l = sda_m & ~sda_oe;

  int nvec = 0, nbad = 0, rx_cnt = 0;
  logic [7:0] last_rx = '0;
  localparam int HALF = 6;

  always #5 clk = ~clk;

  i2c_tgt dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_l), .scl_oe(scl_oe),
    .sda_i(sda_l), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid), .irq(irq)
  );

  always @(negedge clk)
    if (rx_valid) begin
      last_rx = rx_data;
      rx_cnt++;
    end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n = HALF);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w();
    scl_m = 1'b1; w();
    sda_m = 1'b0; w();
    scl_m = 1'b0; w();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w();
    scl_m = 1'b1; w();
    sda_m = 1'b1; w();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w();
      scl_m = 1'b1;
      while (!scl_l) @(negedge clk);
      w();
      scl_m = 1'b0; w();
    end
    sda_m = 1'b1; w();
    scl_m = 1'b1; w();
    ack = !sda_l;
    scl_m = 1'b0; w();
  endtask

  task automatic recv_byte(input logic nack_bit, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w();
      scl_m = 1'b1;
      while (!scl_l) @(negedge clk);
      w();
      b = {b[6:0], sda_l};
      scl_m = 1'b0;
    end
    w(3);
    sda_m = nack_bit; w();
    scl_m = 1'b1; w();
    scl_m = 1'b0; w(3);
    sda_m = 1'b1; w();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    nbad++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic ack;
    logic [7:0] b;
    int cnt0;
    w(5);
    rst_n = 1'b1;
    w(3);
    reg_rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    reg_rd(3'd1, v); chk("R1 addr", v, 16'h0055);
    reg_rd(3'd2, v); chk("R1 enable", v, 0);
    reg_rd(3'd4, v); chk("R1 raw", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sda_oe, scl_oe}, 0);

    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R2 disabled no ack", ack, 0);

    reg_wr(3'd2, 16'h0001);
    reg_wr(3'd1, 16'h0012);
    reg_rd(3'd1, v); chk("R3 addr locked", v, 16'h0055);
    reg_wr(3'd0, 16'h0008);
    reg_rd(3'd0, v); chk("R3 ctrl locked", v, 16'h0000);

    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte(8'(a << 1), ack);
      chk($sformatf("R5 addr %0h", a), ack, a == 8'h55);
      if (a != 8'h55) begin
        send_byte(8'hAA, ack);
        chk("R5 ignored after miss", ack, 0);
      end
      bus_stop();
    end

    bus_start(); send_byte(8'hAA, ack); chk("R6 addr ack", ack, 1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + 11);
      cnt0 = rx_cnt;
      send_byte(d, ack);
      chk("R6 data ack", ack, 1);
      chk("R6 rx byte", last_rx, d);
      chk("R6 one pulse", rx_cnt - cnt0, 1);
    end
    bus_stop();
    reg_rd(3'd3, v); chk("R6 readback", v, 8'(7 * 37 + 11));

    bus_start(); send_byte(8'hAB, ack); chk("R7 read addr ack", ack, 1);
    w(10);
    chk("R7 stretch", scl_oe, 1);
    reg_rd(3'd4, v); chk("R7 raw flag", v, 16'h0020);
    chk("R10 irq masked", irq, 0);
    reg_wr(3'd5, 16'h0020);
    chk("R10 irq unmasked", irq, 1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h00C3;
    #1 chk("R7 held during write", scl_oe, 1);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R7 released next cycle", scl_oe, 0);
    reg_wr(3'd4, 16'h0020);
    reg_rd(3'd4, v); chk("R10 w1c", v, 0);
    chk("R10 irq clear", irq, 0);
    recv_byte(1'b0, b); chk("R8 tx byte", b, 8'hC3);
    w(4);
    chk("R8 ack restretch", scl_oe, 1);
    reg_rd(3'd4, v); chk("R8 second request", v, 16'h0020);
    reg_wr(3'd4, 16'h0020);
    reg_wr(3'd3, 16'h005A);
    recv_byte(1'b1, b); chk("R8 tx byte 2", b, 8'h5A);
    w(4);
    chk("R8 nack release", {sda_oe, scl_oe}, 0);
    reg_rd(3'd4, v); chk("R8 no request after nack", v, 0);
    recv_byte(1'b1, b); chk("R8 idle after nack", b, 8'hFF);
    bus_stop();

    reg_wr(3'd2, 16'h0000);
    reg_wr(3'd0, 16'h0001);
    reg_rd(3'd0, v); chk("R4 illegal rejected", v, 16'h0000);
    reg_wr(3'd0, 16'h0041);
    reg_rd(3'd0, v); chk("R4 legal accepted", v, 16'h0041);
    reg_wr(3'd2, 16'h0001);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R11 target disabled", ack, 0);

    reg_wr(3'd2, 16'h0000);
    reg_wr(3'd0, 16'h0008);
    reg_wr(3'd1, 16'h02A5);
    reg_rd(3'd1, v); chk("R3 addr write when off", v, 16'h02A5);
    reg_wr(3'd2, 16'h0001);

    bus_start(); send_byte(8'hF5, ack); bus_stop();
    chk("R9 read header without match", ack, 0);
    for (int h = 0; h < 4; h++) begin
      bus_start(); send_byte(8'hF0 | 8'(h << 1), ack); bus_stop();
      chk($sformatf("R9 header hi=%0d", h), ack, h == 2);
    end
    bus_start(); send_byte(8'hF4, ack); send_byte(8'hA4, ack); bus_stop();
    chk("R9 low byte miss", ack, 0);
    bus_start(); send_byte(8'hF5, ack); bus_stop();
    chk("R9 match forgotten", ack, 0);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R9 7-bit form rejected", ack, 0);

    bus_start();
    send_byte(8'hF4, ack); chk("R9 first byte", ack, 1);
    send_byte(8'hA5, ack); chk("R9 second byte", ack, 1);
    send_byte(8'h3C, ack); chk("R9 write data", last_rx, 8'h3C);
    bus_start();
    send_byte(8'hF5, ack); chk("R9 repeated start read", ack, 1);
    w(4);
    chk("R9 stretch", scl_oe, 1);
    reg_wr(3'd3, 16'h0096);
    recv_byte(1'b1, b); chk("R9 tx byte", b, 8'h96);
    bus_stop();
    bus_start(); send_byte(8'hF5, ack); bus_stop();
    chk("R9 stop forgets match", ack, 0);

    summary();
  end
endmodule